// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt lines and turns each into an interrupt request according to a 2-bit sense field per line. A field picks one of four modes: low level, any edge, falling edge or rising edge. Edge modes latch an event into a per-line pending flag, which holds until the line's acknowledge pulses or software writes a 1 to that flag bit. Low-level mode latches nothing: the request follows the pin for as long as it is held low. A request reaches its output only when the global interrupt enable input and the line's mask bit are both set. Pins are sensed whatever their direction, so firmware can raise an interrupt by driving one of its own pins.

Lines 3:0 take a wake-capable path. Their pins are compared directly against a single sampled copy, with no dependence on the I/O clock gate, so their edges and low levels are seen while the I/O clock is halted. Lines 7:4 pass through a two-flop synchronizer. Their edges are recognised only while the I/O clock gate input is high, but their low-level detection keeps working when the gate is low.

Software reaches the block through a small write port with four addresses. There are two sense-control registers, each holding four 2-bit fields. Then come the enable mask and a write-1-to-clear flag register. Each register's current value is visible on an output.

Top module: `eic_top`

## Requirements
- R1: After reset both sense registers, the mask and all flags are zero, and no request is asserted.
- R2: The sense field for line n sits at bits 2n+1:2n of `sense_o`. Address 0 writes lines 3:0 (line 0 in bits 1:0) and address 1 writes lines 7:4 (line 4 in bits 1:0). The codes are 00 low level, 01 any edge, 10 falling edge and 11 rising edge. An edge of the opposite direction sets no flag.
- R3: In low-level mode the request is high while the pin is low and drops when the pin returns high. The flag is never set in this mode. On lines 3:0 the request follows the pin with no clock delay, and on lines 7:4 it follows after two clock edges.
- R4: In an edge mode a detected edge sets the line's flag. The flag then holds, and the line requests, until it is cleared.
- R5: `irq_req[n]` is high only when `gie` is high and mask bit n is set. Flags are still set while the line is masked or `gie` is low.
- R6: A high `irq_ack[n]` clears flag n at the next clock edge. If a new edge is detected in the same cycle, the flag stays set.
- R7: Writing address 3 clears every flag whose write-data bit is 1. Bits written as 0 leave their flags unchanged.
- R8: An edge on lines 3:0 sets the flag at the first clock edge after the pin changes, whatever the level of `io_clk_en`. An edge on lines 7:4 sets the flag at the third clock edge.
- R9: While `io_clk_en` is low, edges on lines 7:4 set no flag, and no flag appears for them once the gate reopens. Low-level requests on those lines still work while the gate is low.
- R10: Writing a sense field to low level while the line is enabled and its pin is low raises a request at once. With the mask bit cleared first, the same mode changes raise none.
- R11: Address 2 writes the enable mask. Writes take effect at the clock edge on which `reg_we` is sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_clk_en | input | 1 | I/O clock running; low halts edge detection on lines 7:4 |
| gie | input | 1 | Global interrupt enable |
| line_in | input | 8 | External interrupt pins |
| irq_ack | input | 8 | Per-line acknowledge, clears the pending flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 sense lines 3:0, 1 sense lines 7:4, 2 mask, 3 flag clear |
| reg_wdata | input | 8 | Register write data |
| sense_o | output | 16 | Sense fields, line n at bits 2n+1:2n |
| mask_o | output | 8 | Enable mask |
| flag_o | output | 8 | Pending edge flags |
| irq_req | output | 8 | Per-line interrupt request |

## Verification
The bench counts clock edges from each pin change to the flag. It samples lines 3:0 one edge later and lines 7:4 three edges later, so a design that puts the synchronizer on the wrong half, or drops it, shows up at once. It holds the high lines toggling while the clock gate is closed and then reopens the gate. A design that freezes its history instead of ignoring the edges would raise a late flag at that point. It raises an edge in the same cycle as an acknowledge, which catches a clear-wins priority. It writes zero bits to the flag register, which catches a plain write instead of a write-1-to-clear. It also shows the spurious request from a mode change on an enabled line held low, and shows that masking first prevents it.

// File: rtl/eic_pkg.sv
package eic_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int FIELD_W = 2;

endpackage

// File: rtl/eic_regs.sv
module eic_regs
    import eic_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [FIELD_W*NUM_LINES-1:0] sense_flat,
    output logic [NUM_LINES-1:0]         mask,
    output logic [NUM_LINES-1:0]         flag_clr
);

    localparam int LINES_PER_REG = DATA_W / FIELD_W;
    localparam int NUM_SREGS     = (NUM_LINES + LINES_PER_REG - 1) / LINES_PER_REG;
    localparam int MASK_ADDR     = NUM_SREGS;
    localparam int FLAG_ADDR     = NUM_SREGS + 1;

    typedef struct packed {
        logic [NUM_SREGS-1:0][DATA_W-1:0] sense;
        logic [NUM_LINES-1:0]             mask;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (we) begin
            for (int r = 0; r < NUM_SREGS; r++) begin
                if (addr == ADDR_W'(r)) begin
                    regs_d.sense[r] = wdata;
                end
            end
            if (addr == ADDR_W'(MASK_ADDR)) begin
                regs_d.mask = wdata[NUM_LINES-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '0;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign sense_flat = (FIELD_W*NUM_LINES)'(regs_q.sense);
    assign mask       = regs_q.mask;
    assign flag_clr   = (we && addr == ADDR_W'(FLAG_ADDR)) ? wdata[NUM_LINES-1:0] : '0;

endmodule

// File: rtl/eic_line_detect.sv
module eic_line_detect
    import eic_pkg::*;
#(
    parameter bit ASYNC_PATH  = 1'b0,
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               io_clk_en,
    input  logic               pin,
    input  logic [FIELD_W-1:0] sense,
    input  logic               ack,
    input  logic               clr,
    output logic               flag,
    output logic               req_src
);

    logic   cur;
    logic   prev;
    logic   gate;
    sense_e mode;

    generate
        if (ASYNC_PATH) begin : g_direct
            logic samp_d, samp_q;

            always_comb begin
                samp_d = pin;
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    samp_q <= 1'b1;
                end else begin
                    samp_q <= samp_d;
                end
            end

            assign cur  = pin;
            assign prev = samp_q;
        end else begin : g_synced
            typedef struct packed {
                logic [SYNC_STAGES-1:0] chain;
                logic                   last;
            } sync_t;

            sync_t sync_d, sync_q;

            always_comb begin
                sync_d.chain = {sync_q.chain[SYNC_STAGES-2:0], pin};
                sync_d.last  = sync_q.chain[SYNC_STAGES-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= '1;
                end else begin
                    sync_q <= sync_d;
                end
            end

            assign cur  = sync_q.chain[SYNC_STAGES-1];
            assign prev = sync_q.last;
        end
    endgenerate

    assign gate = ASYNC_PATH ? 1'b1 : io_clk_en;
    assign mode = sense_e'(sense);

    logic rise_evt, fall_evt, hit;
    logic flag_d, flag_q;

    always_comb begin
        rise_evt = cur & ~prev;
        fall_evt = ~cur & prev;
        unique case (mode)
            SENSE_ANY:  hit = rise_evt | fall_evt;
            SENSE_FALL: hit = fall_evt;
            SENSE_RISE: hit = rise_evt;
            default:    hit = 1'b0;
        endcase

        flag_d = flag_q;
        if (ack || clr) begin
            flag_d = 1'b0;
        end
        if (hit && gate) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign flag    = flag_q;
    assign req_src = (mode == SENSE_LOW) ? ~cur : flag_q;

endmodule

// File: rtl/eic_top.sv
module eic_top
    import eic_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int ASYNC_LINES = 4,
    parameter int SYNC_STAGES = 2,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         io_clk_en,
    input  logic                         gie,
    input  logic [NUM_LINES-1:0]         line_in,
    input  logic [NUM_LINES-1:0]         irq_ack,
    input  logic                         reg_we,
    input  logic [ADDR_W-1:0]            reg_addr,
    input  logic [DATA_W-1:0]            reg_wdata,
    output logic [FIELD_W*NUM_LINES-1:0] sense_o,
    output logic [NUM_LINES-1:0]         mask_o,
    output logic [NUM_LINES-1:0]         flag_o,
    output logic [NUM_LINES-1:0]         irq_req
);

    logic [FIELD_W*NUM_LINES-1:0] sense_flat;
    logic [NUM_LINES-1:0]         mask;
    logic [NUM_LINES-1:0]         flag_clr;
    logic [NUM_LINES-1:0]         req_src;
    logic [NUM_LINES-1:0]         flags;

    eic_regs #(
        .NUM_LINES (NUM_LINES),
        .DATA_W    (DATA_W),
        .ADDR_W    (ADDR_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .sense_flat (sense_flat),
        .mask       (mask),
        .flag_clr   (flag_clr)
    );

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
            eic_line_detect #(
                .ASYNC_PATH  (i < ASYNC_LINES),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_det (
                .clk       (clk),
                .rst_n     (rst_n),
                .io_clk_en (io_clk_en),
                .pin       (line_in[i]),
                .sense     (sense_flat[FIELD_W*i +: FIELD_W]),
                .ack       (irq_ack[i]),
                .clr       (flag_clr[i]),
                .flag      (flags[i]),
                .req_src   (req_src[i])
            );
        end
    endgenerate

    assign sense_o = sense_flat;
    assign mask_o  = mask;
    assign flag_o  = flags;
    assign irq_req = {NUM_LINES{gie}} & mask & req_src;

endmodule

// File: rtl/eic_chk.sv
module eic_chk
    import eic_pkg::*;
#(
    parameter int NUM_LINES   = 8,
    parameter int ASYNC_LINES = 4,
    parameter int DATA_W      = 8,
    parameter int ADDR_W      = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         io_clk_en,
    input logic                         gie,
    input logic [NUM_LINES-1:0]         line_in,
    input logic [NUM_LINES-1:0]         irq_ack,
    input logic                         reg_we,
    input logic [ADDR_W-1:0]            reg_addr,
    input logic [DATA_W-1:0]            reg_wdata,
    input logic [FIELD_W*NUM_LINES-1:0] sense_o,
    input logic [NUM_LINES-1:0]         mask_o,
    input logic [NUM_LINES-1:0]         flag_o,
    input logic [NUM_LINES-1:0]         irq_req
);

    localparam int LINES_PER_REG = DATA_W / FIELD_W;
    localparam int NUM_SREGS     = (NUM_LINES + LINES_PER_REG - 1) / LINES_PER_REG;
    localparam int FLAG_ADDR     = NUM_SREGS + 1;

    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (flag_o == '0 && mask_o == '0 && sense_o == '0 && irq_req == '0));

    p_gie_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> irq_req == '0);

    generate
        for (genvar i = 0; i < NUM_LINES; i++) begin : g_prop
            p_flag_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
                (flag_o[i] && !irq_ack[i] &&
                 !(reg_we && reg_addr == ADDR_W'(FLAG_ADDR) && reg_wdata[i]))
                |=> flag_o[i]);

            p_level_no_flag_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (sense_o[FIELD_W*i +: FIELD_W] == 2'b00 && !flag_o[i]) |=> !flag_o[i]);

            p_masked_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
                !mask_o[i] |-> !irq_req[i]);

            if (i >= ASYNC_LINES) begin : g_hi
                p_gated_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    (!io_clk_en && !flag_o[i]) |=> !flag_o[i]);
            end else begin : g_lo
                p_level_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
                    (sense_o[FIELD_W*i +: FIELD_W] == 2'b00 && gie && mask_o[i] && !line_in[i])
                    |-> irq_req[i]);
            end
        end
    endgenerate

endmodule

bind eic_top eic_chk #(
    .NUM_LINES   (NUM_LINES),
    .ASYNC_LINES (ASYNC_LINES),
    .DATA_W      (DATA_W),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_clk_en (io_clk_en),
    .gie       (gie),
    .line_in   (line_in),
    .irq_ack   (irq_ack),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sense_o   (sense_o),
    .mask_o    (mask_o),
    .flag_o    (flag_o),
    .irq_req   (irq_req)
);

// File: tb/sim_eic_top.sv
`timescale 1ns/1ps
module sim_eic_top;

    logic        clk       = 1'b0;
    logic        rst_n     = 1'b0;
    logic        io_clk_en = 1'b1;
    logic        gie       = 1'b0;
    logic [7:0]  line_in   = 8'hFF;
    logic [7:0]  irq_ack   = 8'h00;
    logic        reg_we    = 1'b0;
    logic [1:0]  reg_addr  = 2'd0;
    logic [7:0]  reg_wdata = 8'h00;
    logic [15:0] sense_o;
    logic [7:0]  mask_o;
    logic [7:0]  flag_o;
    logic [7:0]  irq_req;

    eic_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .io_clk_en (io_clk_en),
        .gie       (gie),
        .line_in   (line_in),
        .irq_ack   (irq_ack),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .sense_o   (sense_o),
        .mask_o    (mask_o),
        .flag_o    (flag_o),
        .irq_req   (irq_req)
    );

    always #2 clk = ~clk;

    typedef struct {
        logic [7:0] req;
        logic [7:0] flag;
        string      tag;
    } exp_t;

    exp_t q[$];
    event chk_ev;
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    // Monitor: pops expected items and compares them against the outputs.
    initial begin
        forever begin
            @(chk_ev);
            #0.5;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_chk++;
                if (irq_req !== e.req || flag_o !== e.flag) begin
                    n_fail++;
                    $display("FAIL %s: req=%h flag=%h expected req=%h flag=%h",
                             e.tag, irq_req, flag_o, e.req, e.flag);
                end
            end
        end
    end

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic expect_out(input logic [7:0] r, input logic [7:0] f, input string tag);
        q.push_back('{req: r, flag: f, tag: tag});
        -> chk_ev;
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_we    = 1'b1;
        tick(1);
        reg_we    = 1'b0;
    endtask

    task automatic chk16(input logic [15:0] act, input logic [15:0] exp_v, input string tag);
        n_chk++;
        if (act !== exp_v) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk16(sense_o, 16'h0000, "R1 sense");
        chk16({8'h00, mask_o}, 16'h0000, "R1 mask");
        expect_out(8'h00, 8'h00, "R1 outputs");

        // R2 / R11: lines 0/4 rise, 1/5 fall, 2/6 any, 3/7 low level
        wr(2'd0, 8'h1B);
        wr(2'd1, 8'h1B);
        wr(2'd2, 8'hFF);
        gie = 1'b1;
        chk16(sense_o, 16'h1B1B, "R2 field layout");
        chk16({8'h00, mask_o}, 16'h00FF, "R11 mask write");
        expect_out(8'h00, 8'h00, "R11 idle after setup");

        // R2 / R8: rising on line 0 (low half, one edge)
        line_in[0] = 1'b0;
        tick(4);
        expect_out(8'h00, 8'h00, "R2 falling ignored in rise mode");
        line_in[0] = 1'b1;
        expect_out(8'h00, 8'h00, "R8 no flag before clock");
        tick(1);
        expect_out(8'h01, 8'h01, "R8 low-half rise after one edge");
        line_in[1] = 1'b0;
        tick(1);
        expect_out(8'h03, 8'h03, "R4 falling on line 1");

        // R6 ack, R7 write-1-to-clear
        irq_ack = 8'h01;
        tick(1);
        irq_ack = 8'h00;
        expect_out(8'h02, 8'h02, "R6 ack clears line 0");
        wr(2'd3, 8'h01);
        expect_out(8'h02, 8'h02, "R7 zero bit leaves flag");
        wr(2'd3, 8'h02);
        expect_out(8'h00, 8'h00, "R7 one bit clears flag");

        // R2 falling mode ignores rise; any-edge both ways
        line_in[1] = 1'b1;
        tick(2);
        expect_out(8'h00, 8'h00, "R2 rise ignored in fall mode");
        line_in[2] = 1'b0;
        tick(1);
        expect_out(8'h04, 8'h04, "R2 any-edge falling");
        wr(2'd3, 8'h04);
        line_in[2] = 1'b1;
        tick(1);
        expect_out(8'h04, 8'h04, "R2 any-edge rising");
        wr(2'd3, 8'h04);
        expect_out(8'h00, 8'h00, "R7 clear any-edge");

        // R3 level on low half: immediate, no flag
        line_in[3] = 1'b0;
        expect_out(8'h08, 8'h00, "R3 low-half level immediate");
        tick(3);
        expect_out(8'h08, 8'h00, "R3 level held, no flag");
        line_in[3] = 1'b1;
        expect_out(8'h00, 8'h00, "R3 level drops");

        // R8 high half: flag on third edge
        line_in[4] = 1'b0;
        tick(4);
        expect_out(8'h00, 8'h00, "R2 line 4 falling ignored");
        line_in[4] = 1'b1;
        tick(2);
        expect_out(8'h00, 8'h00, "R8 high-half not yet at edge two");
        tick(1);
        expect_out(8'h10, 8'h10, "R8 high-half flag at edge three");
        wr(2'd3, 8'h10);

        // R3 level on high half: two-edge delay
        line_in[7] = 1'b0;
        tick(1);
        expect_out(8'h00, 8'h00, "R3 high-half level after one edge");
        tick(1);
        expect_out(8'h80, 8'h00, "R3 high-half level after two edges");
        line_in[7] = 1'b1;
        tick(2);
        expect_out(8'h00, 8'h00, "R3 high-half level drops");

        // R9 gated I/O clock
        io_clk_en = 1'b0;
        line_in[5] = 1'b0;
        line_in[6] = 1'b0;
        tick(5);
        expect_out(8'h00, 8'h00, "R9 gated falling edges ignored");
        line_in[5] = 1'b1;
        line_in[6] = 1'b1;
        tick(5);
        expect_out(8'h00, 8'h00, "R9 gated rising edge ignored");
        line_in[7] = 1'b0;
        tick(2);
        expect_out(8'h80, 8'h00, "R9 level works while gated");
        line_in[7] = 1'b1;
        tick(2);
        line_in[0] = 1'b0;
        tick(1);
        line_in[0] = 1'b1;
        tick(1);
        expect_out(8'h01, 8'h01, "R8 low-half edge while gated");
        wr(2'd3, 8'h01);
        io_clk_en = 1'b1;
        tick(4);
        expect_out(8'h00, 8'h00, "R9 no late flag on reopen");

        // R5 gating by gie and mask
        gie = 1'b0;
        line_in[1] = 1'b0;
        tick(1);
        expect_out(8'h00, 8'h02, "R5 flag set with gie low");
        gie = 1'b1;
        expect_out(8'h02, 8'h02, "R5 request with gie high");
        wr(2'd2, 8'hFD);
        expect_out(8'h00, 8'h02, "R5 masked line silent");
        wr(2'd3, 8'h02);
        wr(2'd2, 8'hFF);
        expect_out(8'h00, 8'h00, "R5 restored");
        line_in[1] = 1'b1;
        tick(2);

        // R6 set wins over ack
        line_in[2] = 1'b0;
        irq_ack    = 8'h04;
        tick(1);
        irq_ack    = 8'h00;
        expect_out(8'h04, 8'h04, "R6 new edge beats ack");
        wr(2'd3, 8'h04);
        expect_out(8'h00, 8'h00, "R7 clear after set-wins");

        // R10 mode change with the line held low
        line_in[0] = 1'b0;
        tick(2);
        expect_out(8'h00, 8'h00, "R10 held low in rise mode");
        wr(2'd0, 8'h18);
        expect_out(8'h01, 8'h00, "R10 spurious request when enabled");
        wr(2'd0, 8'h1B);
        expect_out(8'h00, 8'h00, "R10 back to rise mode");
        wr(2'd2, 8'hFE);
        wr(2'd0, 8'h18);
        expect_out(8'h00, 8'h00, "R10 masked change silent");
        wr(2'd0, 8'h1A);
        wr(2'd2, 8'hFF);
        expect_out(8'h00, 8'h00, "R10 safe sequence no request");
        chk16(sense_o, 16'h1B1A, "R10 final sense");

        tick(2);
        finish_run();
    end

endmodule